// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM that holds 64 words of 16 bits. A host drives it by writing a 4-bit control register: one bit is chip select, one is the serial clock and one is the data bit going to the device. The device's serial output is read back in the fourth bit of the same register. All device activity happens on rising edges of the register's serial clock bit, and those edges are found by sampling the register on the system clock. The host therefore bit-bangs every transfer one register write at a time.

Each instruction is nine bits long and is sent most significant bit first. It starts with a 1 bit, followed by a two-bit opcode and a six-bit word address. The device supports several operations: reading a word, writing a word, erasing a word, erasing every word and writing one value to every word. It also has enable and disable commands that guard all programming operations. A programming operation holds the device busy for a fixed, parameterised number of system clocks. While busy, the device ignores new instructions and drives 0 on its data output. When programming completes, the output changes to 1.

Top module: `serial_eeprom_3w`

## Requirements
- R1: After reset, all four bits of `host_rdata` read 0, programming is disabled, and every word of the store holds 16'hFFFF.
- R2: Bit 0 of the control register is chip select, bit 1 is the serial clock and bit 2 is the host-to-device data bit. After a write, `host_rdata[2:0]` returns the value written. `host_rdata[3]` is the device output: the value written to bit 3 is ignored, and the output reads 0 whenever chip select is 0.
- R3: With chip select at 1, the device samples the data bit on every 0-to-1 change of the serial clock bit. It ignores 0 bits until it sees a 1, which is the start bit. The next eight bits, MSB first, form the opcode (two bits) and the address (six bits).
- R4: Opcode 10 is a read. After the last address bit, the output shows a 0 bit. Each later rising clock edge then presents the next bit of the addressed word, MSB first. Once all 16 bits are out, further edges produce 0, and the address does not advance to the next word.
- R5: Opcode 01 is a write. It takes 16 further data bits, MSB first, and stores them at the address.
- R6: Opcode 11 is an erase. It sets the addressed word to 16'hFFFF.
- R7: Opcode 00 is a special command, chosen by the top two address bits. A value of 11 enables programming and 00 disables it. While programming is disabled, a write, an erase, an erase-all or a write-all leaves the store unchanged and starts no busy period.
- R8: Under opcode 00, address bits 10 select erase-all, which sets every word to 16'hFFFF. Address bits 01 select write-all, which takes 16 data bits and stores that value in every word.
- R9: An accepted programming operation keeps the device busy for PROG_CYCLES system clocks, starting at the clock edge that takes in its last bit. While busy, the output reads 0. After that, with chip select at 1, the output reads 1 until the next start bit is taken.
- R10: A start bit that arrives while the device is busy is ignored.
- R11: Taking chip select to 0 at any point abandons the instruction in progress. The device then waits for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Loads host_wdata into the control register |
| host_wdata | input | 4 | Control register value: bit 0 chip select, bit 1 serial clock, bit 2 data to device (bit 3 ignored) |
| host_rdata | output | 4 | Bits 2:0 hold the control register; bit 3 is the device data or status output |

## Verification
Most internal state problems show up at the data output bit within one serial clock edge. A miscounted framing counter shifts the opcode and address, so a read returns the wrong word, or a write lands in the wrong place. That error appears on the next read-back. A wrong protection flag or a wrong busy timer shows up either as a store that changes when it should not, or as a ready bit that rises on the wrong system clock. The bench checks the ready bit against a reference model on every clock, so that kind of error is caught in the cycle where it happens.

// File: rtl/sep_pkg.sv
// Shared constants and types for the three-wire serial EEPROM model.
// Assumes callers use the host register bit positions given here.
package sep_pkg;
    localparam int HOST_W = 4;
    localparam int BIT_CS = 0;
    localparam int BIT_SK = 1;
    localparam int BIT_DI = 2;
    localparam int BIT_DO = 3;
    localparam int OPC_W  = 2;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_READ  = 3'd2,
        PH_WDATA = 3'd3,
        PH_HOLD  = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } opcode_t;

    typedef enum logic [1:0] {
        SP_LOCK   = 2'b00,
        SP_FILL   = 2'b01,
        SP_WIPE   = 2'b10,
        SP_UNLOCK = 2'b11
    } special_t;
endpackage

// File: rtl/sep_host_port.sv
// Host-facing 4-bit control register with serial clock edge detection.
// Assumes the host changes at most one register value per system clock.
// Bit 3 of the write data is discarded; bit 3 of read data is the device output.
module sep_host_port
    import sep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              dev_do,
    output logic [HOST_W-1:0] host_rdata,
    output logic              cs,
    output logic              sk_rise,
    output logic              di
);
    logic [HOST_W-2:0] ctl_q;
    logic              sk_d;

    // Hold the host control bits and the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            sk_d  <= 1'b0;
        end else begin
            sk_d <= ctl_q[BIT_SK];
            if (host_wr) begin
                ctl_q <= host_wdata[HOST_W-2:0];
            end
        end
    end

    // Decode pins and assemble the read-back word.
    always_comb begin
        cs         = ctl_q[BIT_CS];
        di         = ctl_q[BIT_DI];
        sk_rise    = ctl_q[BIT_SK] & ~sk_d;
        host_rdata = {dev_do, ctl_q};
    end
endmodule

// File: rtl/sep_store.sv
// Word store and programming timer for the serial EEPROM model.
// A program request writes the selected words at once and then holds busy
// for PROG_CYCLES clocks. Assumes requests arrive only while not busy.
module sep_store #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              prog_all,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  hit;
    logic [TMR_W-1:0]  tmr_q;

    // One write strobe per word: selected by address or by the all-words flag.
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign hit[g] = prog_req & (prog_all | (prog_addr == ADDR_W'(g)));
    end

    // Update the selected words; reset leaves every word erased.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '1;
            end else if (hit[i]) begin
                mem_q[i] <= prog_data;
            end
        end
    end

    // Count down the programming window after each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (prog_req) begin
            tmr_q <= TMR_W'(PROG_CYCLES);
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    // Present the addressed word and the busy level.
    always_comb begin
        rd_word = mem_q[rd_addr];
        busy    = (tmr_q != '0);
    end
endmodule

// File: rtl/sep_ctrl.sv
// Instruction framing, decode, read shifter and protection for the serial
// EEPROM model. Acts only on rising serial clock edges while chip select is
// high. Assumes the store read port is combinational.
module sep_ctrl
    import sep_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk_rise,
    input  logic              di,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              prog_req,
    output logic              prog_all,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              ewen,
    output phase_t            phase,
    output logic              rd_bit,
    output logic              dev_do
);
    localparam int BODY_BITS = OPC_W + ADDR_W;
    localparam int CNT_MAX   = (DATA_W > BODY_BITS) ? DATA_W : BODY_BITS;
    localparam int CNT_W     = $clog2(CNT_MAX) + 1;

    phase_t              phase_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [BODY_BITS-2:0] sreg_q;
    logic [DATA_W-1:0]   wbuf_q;
    logic [DATA_W-1:0]   rshift_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                all_q;
    logic                ewen_q;
    logic                armed_q;
    logic                rbit_q;

    logic [BODY_BITS-1:0] frame;
    logic [ADDR_W-1:0]    addr_f;
    logic [DATA_W-1:0]    wbuf_nx;
    opcode_t              op;
    special_t             sel;
    logic                 step, start_ok, body_done, data_done, wants_erase;

    // Decode the current frame and the events of this clock.
    always_comb begin
        step        = cs & sk_rise;
        frame       = {sreg_q, di};
        addr_f      = frame[ADDR_W-1:0];
        op          = opcode_t'(frame[BODY_BITS-1 -: OPC_W]);
        sel         = special_t'(frame[ADDR_W-1 -: 2]);
        wbuf_nx     = {wbuf_q[DATA_W-2:0], di};
        start_ok    = step & (phase_q == PH_IDLE) & di & ~busy;
        body_done   = step & (phase_q == PH_CMD) & (cnt_q == CNT_W'(BODY_BITS - 1));
        data_done   = step & (phase_q == PH_WDATA) & (cnt_q == CNT_W'(DATA_W - 1));
        wants_erase = (op == OP_ERASE) | ((op == OP_SPECIAL) & (sel == SP_WIPE));
    end

    // Form the programming request presented to the store.
    always_comb begin
        prog_req  = ewen_q & ((body_done & wants_erase) | data_done);
        prog_all  = (phase_q == PH_CMD) ? (op == OP_SPECIAL) : all_q;
        prog_addr = (phase_q == PH_CMD) ? addr_f : addr_q;
        prog_data = (phase_q == PH_CMD) ? '1 : wbuf_nx;
        rd_addr   = addr_f;
    end

    // Framing state machine: start bit, opcode and address, then data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            sreg_q  <= '0;
            wbuf_q  <= '0;
            addr_q  <= '0;
            all_q   <= 1'b0;
        end else if (!cs) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (sk_rise) begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_ok) begin
                        phase_q <= PH_CMD;
                        cnt_q   <= '0;
                    end
                end
                PH_CMD: begin
                    sreg_q <= frame[BODY_BITS-2:0];
                    cnt_q  <= cnt_q + 1'b1;
                    if (body_done) begin
                        cnt_q <= '0;
                        unique case (op)
                            OP_READ:  phase_q <= PH_READ;
                            OP_WRITE: begin
                                phase_q <= PH_WDATA;
                                addr_q  <= addr_f;
                                all_q   <= 1'b0;
                            end
                            OP_ERASE: phase_q <= PH_HOLD;
                            OP_SPECIAL: begin
                                if (sel == SP_FILL) begin
                                    phase_q <= PH_WDATA;
                                    all_q   <= 1'b1;
                                end else begin
                                    phase_q <= PH_HOLD;
                                end
                            end
                            default: phase_q <= PH_HOLD;
                        endcase
                    end
                end
                PH_WDATA: begin
                    wbuf_q <= wbuf_nx;
                    cnt_q  <= cnt_q + 1'b1;
                    if (data_done) begin
                        phase_q <= PH_HOLD;
                    end
                end
                PH_READ, PH_HOLD: begin
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Read shifter: dummy zero at decode, then word bits MSB first, then zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rshift_q <= '0;
            rbit_q   <= 1'b0;
        end else if (body_done && op == OP_READ) begin
            rshift_q <= rd_word;
            rbit_q   <= 1'b0;
        end else if (step && phase_q == PH_READ) begin
            rbit_q   <= rshift_q[DATA_W-1];
            rshift_q <= {rshift_q[DATA_W-2:0], 1'b0};
        end
    end

    // Protection flag and ready-status arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ewen_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (body_done && op == OP_SPECIAL) begin
                if (sel == SP_UNLOCK) ewen_q <= 1'b1;
                if (sel == SP_LOCK)   ewen_q <= 1'b0;
            end
            if (prog_req) begin
                armed_q <= 1'b1;
            end else if (start_ok) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Serial output: read bit during reads, ready status otherwise.
    always_comb begin
        dev_do = cs & ((phase_q == PH_READ) ? rbit_q : (armed_q & ~busy));
        ewen   = ewen_q;
        phase  = phase_q;
        rd_bit = rbit_q;
    end
endmodule

// File: rtl/serial_eeprom_3w.sv
// Top of the three-wire serial EEPROM model: host register, controller and
// word store. Assumes a single system clock and synchronous active-low reset.
module serial_eeprom_3w
    import sep_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata
);
    logic              cs_w, sk_rise_w, di_w, dev_do_w, busy_w;
    logic              prog_req_w, prog_all_w, ewen_w, rd_bit_w;
    logic [ADDR_W-1:0] prog_addr_w, rd_addr_w;
    logic [DATA_W-1:0] prog_data_w, rd_word_w;
    phase_t            phase_w;

    sep_host_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .dev_do     (dev_do_w),
        .host_rdata (host_rdata),
        .cs         (cs_w),
        .sk_rise    (sk_rise_w),
        .di         (di_w)
    );

    sep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs_w),
        .sk_rise   (sk_rise_w),
        .di        (di_w),
        .busy      (busy_w),
        .rd_word   (rd_word_w),
        .rd_addr   (rd_addr_w),
        .prog_req  (prog_req_w),
        .prog_all  (prog_all_w),
        .prog_addr (prog_addr_w),
        .prog_data (prog_data_w),
        .ewen      (ewen_w),
        .phase     (phase_w),
        .rd_bit    (rd_bit_w),
        .dev_do    (dev_do_w)
    );

    sep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_req  (prog_req_w),
        .prog_all  (prog_all_w),
        .prog_addr (prog_addr_w),
        .prog_data (prog_data_w),
        .rd_addr   (rd_addr_w),
        .rd_word   (rd_word_w),
        .busy      (busy_w)
    );
endmodule

// File: rtl/sep_chk.sv
// Assertion checker for the serial EEPROM model, bound to the top module.
// Observes ports and signals exchanged between the host port, controller
// and store.
module sep_chk
    import sep_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [HOST_W-1:0] host_wdata,
    input logic [HOST_W-1:0] host_rdata,
    input logic              cs,
    input logic              busy,
    input logic              ewen,
    input phase_t            phase,
    input logic              rd_bit
);
    // R2: register bits 2:0 echo the last host write.
    p_reg_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (host_rdata[2:0] == $past(host_wdata[2:0])));

    // R4: the first output bit of a read is the dummy zero.
    p_read_dummy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && $past(phase) != PH_READ) |-> !rd_bit);

    // R7: a busy period starts only while programming is enabled.
    p_prog_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ewen));

    // R9: the output reads 0 throughout the busy window.
    p_busy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_rdata[BIT_DO]);

    // R10: no instruction is started while busy.
    p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_IDLE) |=> (phase != PH_CMD));

    // R11: dropping chip select returns the framing logic to idle.
    p_cs_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (phase == PH_IDLE));
endmodule

bind serial_eeprom_3w sep_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cs         (cs_w),
    .busy       (busy_w),
    .ewen       (ewen_w),
    .phase      (phase_w),
    .rd_bit     (rd_bit_w)
);

// File: tb/tb_serial_eeprom_3w.sv
`timescale 1ns/1ps
module tb_serial_eeprom_3w;
    localparam int P_CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_wr = 1'b0;
    logic [3:0] tb_wdata = 4'h0;
    logic [3:0] host_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit mdl_on = 0;

    always #2.5 clk = ~clk;

    serial_eeprom_3w #(.ADDR_W(6), .DATA_W(16), .PROG_CYCLES(P_CYC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (tb_wr),
        .host_wdata (tb_wdata),
        .host_rdata (host_rdata)
    );

    // ---------------- behavioural reference model ----------------
    int m_ctl, m_skd, m_phase, m_cnt, m_body, m_wbuf, m_addr, m_all;
    int m_ewen, m_armed, m_timer, m_rbit;
    int m_mem [64];
    bit m_rq [$];
    int mcs, mdi, mrise, mbsy, mprog, mpall, mpaddr, mpdata, mop, ma, msel;
    logic [3:0] m_exp;

    // phases: 0 idle, 1 command, 2 read, 3 data, 4 hold
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 0; m_skd = 0; m_phase = 0; m_cnt = 0; m_body = 0;
            m_wbuf = 0; m_addr = 0; m_all = 0; m_ewen = 0; m_armed = 0;
            m_timer = 0; m_rbit = 0; m_rq.delete();
            for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
        end else begin
            mcs = m_ctl & 1; mdi = (m_ctl >> 2) & 1;
            mrise = ((m_ctl >> 1) & 1) && !m_skd;
            mbsy = (m_timer != 0);
            mprog = 0; mpall = 0; mpaddr = 0; mpdata = 0;
            if (!mcs) begin
                m_phase = 0; m_cnt = 0;
            end else if (mrise) begin
                case (m_phase)
                    0: if (mdi && !mbsy) begin m_phase = 1; m_cnt = 0; m_armed = 0; m_body = 0; end
                    1: begin
                        m_body = ((m_body << 1) | mdi) & 255;
                        if (m_cnt == 7) begin
                            m_cnt = 0; mop = (m_body >> 6) & 3; ma = m_body & 63; msel = (ma >> 4) & 3;
                            case (mop)
                                2: begin
                                    m_phase = 2; m_rbit = 0; m_rq.delete();
                                    for (int i = 15; i >= 0; i--) m_rq.push_back(bit'((m_mem[ma] >> i) & 1));
                                end
                                1: begin m_phase = 3; m_addr = ma; m_all = 0; end
                                3: begin
                                    m_phase = 4;
                                    if (m_ewen) begin mprog = 1; mpaddr = ma; mpdata = 16'hFFFF; end
                                end
                                default: begin
                                    if (msel == 1) begin m_phase = 3; m_all = 1; end
                                    else m_phase = 4;
                                    if (msel == 3) m_ewen = 1;
                                    if (msel == 0) m_ewen = 0;
                                    if (msel == 2 && m_ewen) begin mprog = 1; mpall = 1; mpdata = 16'hFFFF; end
                                end
                            endcase
                        end else m_cnt++;
                    end
                    3: begin
                        m_wbuf = ((m_wbuf << 1) | mdi) & 16'hFFFF;
                        if (m_cnt == 15) begin
                            m_phase = 4;
                            if (m_ewen) begin mprog = 1; mpall = m_all; mpaddr = m_addr; mpdata = m_wbuf; end
                        end
                        m_cnt++;
                    end
                    2: m_rbit = (m_rq.size() > 0) ? int'(m_rq.pop_front()) : 0;
                    default: ;
                endcase
            end
            if (mprog) m_timer = P_CYC;
            else if (m_timer != 0) m_timer--;
            if (mprog) begin
                m_armed = 1;
                for (int i = 0; i < 64; i++) if (mpall || i == mpaddr) m_mem[i] = mpdata;
            end
            m_skd = (m_ctl >> 1) & 1;
            if (tb_wr) m_ctl = tb_wdata[2:0];
        end
    end

    // Compare the ports against the model on every clock (R1, R2, R3, R9).
    always @(negedge clk) begin
        if (mdl_on && !done) begin
            m_exp[2:0] = m_ctl[2:0];
            m_exp[3] = (m_ctl & 1) && ((m_phase == 2) ? (m_rbit != 0) : (m_armed && m_timer == 0));
            n_chk++;
            if (host_rdata !== m_exp) begin
                n_fail++;
                $display("FAIL model R3/R9 at %0t: actual %b expected %b", $time, host_rdata, m_exp);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] v);
        @(negedge clk); tb_wr = 1'b1; tb_wdata = v;
        @(negedge clk); tb_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic dout);
        put({1'b0, b, 1'b0, 1'b1});
        put({1'b0, b, 1'b1, 1'b1});
        dout = host_rdata[3];
    endtask

    task automatic send_frame(input int op, input int a, output logic last);
        logic d;
        clk_bit(1'b1, d);
        for (int i = 1; i >= 0; i--) clk_bit(logic'((op >> i) & 1), d);
        for (int i = 5; i >= 0; i--) clk_bit(logic'((a >> i) & 1), d);
        last = d;
    endtask

    task automatic send_data(input logic [15:0] w);
        logic d;
        for (int i = 15; i >= 0; i--) clk_bit(w[i], d);
    endtask

    task automatic read_word(input int a, output logic [15:0] w, output logic dummy, output logic tail);
        logic d;
        put(4'b0001);
        send_frame(2, a, dummy);
        w = '0;
        for (int i = 0; i < 16; i++) begin clk_bit(1'b0, d); w = {w[14:0], d}; end
        clk_bit(1'b0, tail);
        put(4'b0000);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!host_rdata[3] && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic special(input int sel);
        logic d;
        put(4'b0001);
        send_frame(0, sel << 4, d);
        put(4'b0000);
    endtask

    logic [15:0] w;
    logic dm, tl, d;
    int n;

    initial begin
        repeat (3) @(posedge clk);
        mdl_on = 1;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rdata", host_rdata, 0);

        // R2: bit 3 written is ignored, low bits echo
        put(4'b1110);
        check("R2 echo", host_rdata, 4'b0110);
        put(4'b0000);

        // R1 erased after reset; R4 dummy and tail
        read_word(0, w, dm, tl);
        check("R1 word0 erased", w, 16'hFFFF);
        check("R4 dummy bit", dm, 0);
        check("R4 tail zero", tl, 0);

        // R7: write while disabled is ignored
        put(4'b0001);
        send_frame(1, 3, d);
        send_data(16'h1234);
        check("R7 no busy when locked", host_rdata[3], 0);
        put(4'b0000);
        read_word(3, w, dm, tl);
        check("R7 locked write ignored", w, 16'hFFFF);

        // R7 enable; R5 write; R9 busy length
        special(3);
        put(4'b0001);
        send_frame(1, 3, d);
        send_data(16'hA5C3);
        wait_ready(n);
        check("R9 busy cycles", n, P_CYC - 1);
        check("R9 ready high", host_rdata[3], 1);
        put(4'b0000);
        read_word(3, w, dm, tl);
        check("R5 write readback", w, 16'hA5C3);
        check("R4 no auto increment", tl, 0);
        read_word(4, w, dm, tl);
        check("R5 neighbour untouched", w, 16'hFFFF);

        // R3: leading zeros before the start bit
        put(4'b0001);
        for (int i = 0; i < 3; i++) clk_bit(1'b0, d);
        send_frame(2, 3, dm);
        w = '0;
        for (int i = 0; i < 16; i++) begin clk_bit(1'b0, d); w = {w[14:0], d}; end
        put(4'b0000);
        check("R3 leading zeros", w, 16'hA5C3);

        // R11: abort a write by dropping chip select
        put(4'b0001);
        send_frame(1, 7, d);
        for (int i = 0; i < 5; i++) clk_bit(1'b1, d);
        put(4'b0000);
        put(4'b0001);
        check("R11 abort no busy", host_rdata[3], 0);
        put(4'b0000);
        read_word(7, w, dm, tl);
        check("R11 aborted write", w, 16'hFFFF);

        // R10: start bit during busy ignored
        put(4'b0001);
        send_frame(1, 8, d);
        send_data(16'h0F0F);
        put(4'b0000);
        put(4'b0001);
        clk_bit(1'b1, d);
        check("R10 busy during start", d, 0);
        wait_ready(n);
        send_frame(2, 8, dm);
        w = '0;
        for (int i = 0; i < 16; i++) begin clk_bit(1'b0, d); w = {w[14:0], d}; end
        put(4'b0000);
        check("R10 frame stays aligned", w, 16'h0F0F);

        // R6: erase a word
        put(4'b0001);
        send_frame(3, 3, d);
        wait_ready(n);
        check("R6 erase busy", n, P_CYC - 1);
        put(4'b0000);
        read_word(3, w, dm, tl);
        check("R6 erase", w, 16'hFFFF);

        // R8: write-all
        put(4'b0001);
        send_frame(0, 1 << 4, d);
        send_data(16'h3C5A);
        wait_ready(n);
        put(4'b0000);
        read_word(0, w, dm, tl);
        check("R8 fill word0", w, 16'h3C5A);
        read_word(63, w, dm, tl);
        check("R8 fill word63", w, 16'h3C5A);

        // R7: disable then erase is ignored
        special(0);
        put(4'b0001);
        send_frame(3, 0, d);
        put(4'b0000);
        read_word(0, w, dm, tl);
        check("R7 locked erase ignored", w, 16'h3C5A);

        // R8: erase-all after enabling
        special(3);
        put(4'b0001);
        send_frame(0, 2 << 4, d);
        wait_ready(n);
        check("R8 wipe busy", n, P_CYC - 1);
        put(4'b0000);
        read_word(17, w, dm, tl);
        check("R8 wipe word17", w, 16'hFFFF);

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule